// File: doc/BRIEF.md
# SDRAM Bank State Tracker and Command Rule Checker

This block watches the command stream sent to a four-bank synchronous DRAM and keeps a model of every bank's state. It decodes each cycle's control strobes, clock-enable, bank select and address bit 10. It moves each bank through idle, opening, open, closing and auto-closing states, and counts every recovery window in clock cycles. Each command is judged against the rules for the state of the bank it targets, and also against the global lockouts that follow refresh and mode loading.

A command that breaks a rule is not applied to the model. One cycle after the command, the block raises a single-cycle violation flag together with a reason code. The bank states and an all-banks-idle flag are brought out, so a memory controller under test, or a bus monitor inside a larger bench, can compare its own view against this one. All timing limits are parameters.

Top module: `bank_rule_monitor`

## Requirements
- R1: A cycle with `cs_n` high, with `cke` low, or with the no-operation code {cs_n,ras_n,cas_n,we_n} = 0111 is never a violation and changes no bank state. The command codes are ACTIVATE 0011, READ 0101, WRITE 0100, BURST STOP 0110, PRECHARGE 0010, REFRESH 0001 and MODE LOAD 0000.
- R2: A command registered at edge n is reported after that same edge. `viol` is 1 for exactly that cycle, and `viol_code` carries the reason (1..8, listed below), or 0 when the command is legal. A rejected command leaves every bank state unchanged. After reset all banks read state 0 (idle), `all_idle` is 1 and `viol` is 0. The bank state codes in `bank_state[3*i+:3]` are 0 idle, 1 opening, 2 open, 3 closing and 4 auto-closing.
- R3: ACTIVATE to an idle bank puts it in state 1 for T_RCD cycles, after which it reads state 2. Any ACTIVATE, READ, WRITE or PRECHARGE aimed at a bank in state 1, 3 or 4 gives code 4.
- R4: READ or WRITE to an idle bank gives code 5. ACTIVATE to a bank that is not idle and not in a timed state gives code 6.
- R5: PRECHARGE with `a10` low closes the selected open bank: it reads state 3 for T_RP cycles and then 0. PRECHARGE to an idle bank is legal and has no effect.
- R6: PRECHARGE with `a10` high targets every bank and ignores `bank`. It is rejected with code 4 if any bank is in a timed state. Otherwise it closes all open banks.
- R7: READ or WRITE with `a10` high puts the bank in state 4 for BURST_LEN + T_RP cycles, after which it is idle. Any command to that bank during this time gives code 4.
- R8: REFRESH or MODE LOAD while any bank is not idle gives code 3.
- R9: For T_RC cycles after an accepted REFRESH, any command gives code 1. For T_MRD cycles after an accepted MODE LOAD, any command gives code 2.
- R10: An ACTIVATE fewer than T_RRD cycles after the previous accepted ACTIVATE gives code 8.
- R11: A PRECHARGE that reaches an open bank fewer than T_RAS cycles after that bank's ACTIVATE gives code 7.
- R12: When several rules are broken at once, the reported code is the first that applies in the order 1, 2, 3, 4, 5, 6, 7, 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cke | input | 1 | Clock enable; low turns the cycle into no command |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| bank | input | BANK_W | Bank select |
| a10 | input | 1 | Auto-close on read/write, all-banks on precharge |
| bank_state | output | 3*NUM_BANKS | State code of each bank, bank i at [3i+2:3i] |
| all_idle | output | 1 | Every bank is in state 0 |
| viol | output | 1 | One-cycle flag for a rejected command |
| viol_code | output | 4 | Reason of the rejected command, 0 when none |

## Verification
The bench targets the last cycle of each window and the cycle just after it. Examples are a read one cycle after activation, an activate at T_RC-1 after refresh, and a precharge at T_RAS-1 and again at T_RAS. An off-by-one counter would flag the legal command or pass the illegal one. A precharge-all aimed at an idle bank while another bank auto-closes catches a design that honours `bank` on that command. An activate to an already open bank inside the T_RRD window checks the priority order, since a wrong order reports code 8 instead of 6. Dropped commands are checked through `bank_state`, so a design that applies a rejected precharge shows a closing bank where an open one belongs.

// File: rtl/bank_mon_pkg.sv
package bank_mon_pkg;

   typedef enum logic [2:0] {
      BK_IDLE      = 3'd0,
      BK_OPENING   = 3'd1,
      BK_OPEN      = 3'd2,
      BK_CLOSING   = 3'd3,
      BK_AUTOCLOSE = 3'd4
   } bank_st_e;

   typedef enum logic [2:0] {
      OP_NONE, OP_ACT, OP_RD, OP_WR, OP_STOP, OP_PRE, OP_REF, OP_MODE
   } op_e;

   typedef enum logic [3:0] {
      RSN_NONE       = 4'd0,
      RSN_REF_LOCK   = 4'd1,
      RSN_MODE_LOCK  = 4'd2,
      RSN_NOT_IDLE   = 4'd3,
      RSN_BANK_BUSY  = 4'd4,
      RSN_ROW_CLOSED = 4'd5,
      RSN_ROW_OPEN   = 4'd6,
      RSN_RAS        = 4'd7,
      RSN_RRD        = 4'd8
   } reason_e;

endpackage

// File: rtl/cmd_decode.sv
module cmd_decode
   import bank_mon_pkg::*;
(
   input  logic cke,
   input  logic cs_n,
   input  logic ras_n,
   input  logic cas_n,
   input  logic we_n,
   output op_e  op
);

   always_comb begin
      op = OP_NONE;
      if (cke && !cs_n) begin
         unique case ({ras_n, cas_n, we_n})
            3'b011:  op = OP_ACT;
            3'b101:  op = OP_RD;
            3'b100:  op = OP_WR;
            3'b110:  op = OP_STOP;
            3'b010:  op = OP_PRE;
            3'b001:  op = OP_REF;
            3'b000:  op = OP_MODE;
            default: op = OP_NONE;
         endcase
      end
   end

endmodule

// File: rtl/lock_timer.sv
module lock_timer #(
   parameter int SPAN = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy
);

   localparam int CW = (SPAN > 1) ? $clog2(SPAN) : 1;

   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt <= '0;
      else if (start)
         cnt <= CW'(SPAN - 1);
      else if (cnt != '0)
         cnt <= cnt - 1'b1;
   end

   assign busy = (cnt != '0);

endmodule

// File: rtl/bank_fsm.sv
module bank_fsm
   import bank_mon_pkg::*;
#(
   parameter int T_RCD     = 2,
   parameter int T_RP      = 2,
   parameter int T_RAS     = 4,
   parameter int BURST_LEN = 4
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     go,
   input  op_e      op,
   input  logic     auto_pre,
   output bank_st_e st,
   output logic     ras_met
);

   localparam int BUSY_AP = BURST_LEN + T_RP;
   localparam int MAXT    = (T_RCD > BUSY_AP) ? T_RCD : BUSY_AP;
   localparam int CW      = $clog2(MAXT + 1);
   localparam int RW      = $clog2(T_RAS + 1);

   logic [CW-1:0] cnt;
   logic [RW-1:0] ras;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st  <= BK_IDLE;
         cnt <= '0;
         ras <= '0;
      end else begin
         unique case (st)
            BK_IDLE: begin
               if (go && op == OP_ACT) begin
                  st  <= BK_OPENING;
                  cnt <= CW'(T_RCD - 1);
                  ras <= RW'(1);
               end
            end
            BK_OPENING: begin
               if (cnt == CW'(1)) st <= BK_OPEN;
               cnt <= cnt - 1'b1;
               if (ras != RW'(T_RAS)) ras <= ras + 1'b1;
            end
            BK_OPEN: begin
               if (ras != RW'(T_RAS)) ras <= ras + 1'b1;
               if (go) begin
                  if (op == OP_PRE) begin
                     st  <= BK_CLOSING;
                     cnt <= CW'(T_RP - 1);
                  end else if ((op == OP_RD || op == OP_WR) && auto_pre) begin
                     st  <= BK_AUTOCLOSE;
                     cnt <= CW'(BUSY_AP - 1);
                  end
               end
            end
            BK_CLOSING, BK_AUTOCLOSE: begin
               if (cnt == CW'(1)) st <= BK_IDLE;
               cnt <= cnt - 1'b1;
            end
            default: st <= BK_IDLE;
         endcase
      end
   end

   assign ras_met = (ras == RW'(T_RAS));

endmodule

// File: rtl/bank_rule_monitor.sv
module bank_rule_monitor
   import bank_mon_pkg::*;
#(
   parameter int   NUM_BANKS = 4,
   parameter int   T_RCD     = 2,
   parameter int   T_RP      = 2,
   parameter int   T_RC      = 7,
   parameter int   T_RRD     = 2,
   parameter int   T_RAS     = 4,
   parameter int   T_MRD     = 2,
   parameter int   BURST_LEN = 4,
   localparam int  BANK_W    = $clog2(NUM_BANKS)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   cke,
   input  logic                   cs_n,
   input  logic                   ras_n,
   input  logic                   cas_n,
   input  logic                   we_n,
   input  logic [BANK_W-1:0]      bank,
   input  logic                   a10,
   output logic [3*NUM_BANKS-1:0] bank_state,
   output logic                   all_idle,
   output logic                   viol,
   output logic [3:0]             viol_code
);

   // elaboration-time parameter checks
   if (NUM_BANKS < 2 || (1 << BANK_W) != NUM_BANKS) begin : g_bad_banks
      $error("NUM_BANKS must be a power of two, at least 2");
   end
   if (T_RCD < 2 || T_RP < 2 || T_MRD < 2 || T_RC < 2) begin : g_bad_windows
      $error("T_RCD, T_RP, T_MRD and T_RC must be at least 2");
   end
   if (T_RRD < 1 || BURST_LEN < 1 || T_RAS < T_RCD) begin : g_bad_misc
      $error("T_RRD and BURST_LEN must be positive, T_RAS at least T_RCD");
   end

   op_e      op;
   reason_e  rsn;
   logic     accept, bank_op;
   logic     ref_busy, mode_busy, rrd_busy;
   logic [NUM_BANKS-1:0] sel, busy_v, idle_v, open_v, ras_ok_v;
   bank_st_e st [NUM_BANKS];

   cmd_decode i_decode (
      .cke   (cke),
      .cs_n  (cs_n),
      .ras_n (ras_n),
      .cas_n (cas_n),
      .we_n  (we_n),
      .op    (op)
   );

   assign bank_op = (op == OP_ACT) || (op == OP_RD) || (op == OP_WR) || (op == OP_PRE);

   for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
      assign sel[i]    = (op == OP_PRE && a10) || (bank == BANK_W'(i));
      assign idle_v[i] = (st[i] == BK_IDLE);
      assign open_v[i] = (st[i] == BK_OPEN);
      assign busy_v[i] = (st[i] == BK_OPENING) || (st[i] == BK_CLOSING) ||
                         (st[i] == BK_AUTOCLOSE);

      bank_fsm #(
         .T_RCD     (T_RCD),
         .T_RP      (T_RP),
         .T_RAS     (T_RAS),
         .BURST_LEN (BURST_LEN)
      ) i_fsm (
         .clk      (clk),
         .rst_n    (rst_n),
         .go       (accept && bank_op && sel[i]),
         .op       (op),
         .auto_pre (a10),
         .st       (st[i]),
         .ras_met  (ras_ok_v[i])
      );

      assign bank_state[3*i +: 3] = st[i];
   end

   assign all_idle = &idle_v;

   lock_timer #(.SPAN(T_RC)) i_ref_lock (
      .clk (clk), .rst_n (rst_n), .start (accept && op == OP_REF), .busy (ref_busy)
   );
   lock_timer #(.SPAN(T_MRD)) i_mode_lock (
      .clk (clk), .rst_n (rst_n), .start (accept && op == OP_MODE), .busy (mode_busy)
   );
   lock_timer #(.SPAN(T_RRD)) i_rrd_lock (
      .clk (clk), .rst_n (rst_n), .start (accept && op == OP_ACT), .busy (rrd_busy)
   );

   // rule evaluation, earliest rule wins
   always_comb begin
      rsn = RSN_NONE;
      if (op != OP_NONE) begin
         if (ref_busy)
            rsn = RSN_REF_LOCK;
         else if (mode_busy)
            rsn = RSN_MODE_LOCK;
         else if ((op == OP_REF || op == OP_MODE) && !all_idle)
            rsn = RSN_NOT_IDLE;
         else if (bank_op && |(sel & busy_v))
            rsn = RSN_BANK_BUSY;
         else if ((op == OP_RD || op == OP_WR) && idle_v[bank])
            rsn = RSN_ROW_CLOSED;
         else if (op == OP_ACT && !idle_v[bank])
            rsn = RSN_ROW_OPEN;
         else if (op == OP_PRE && |(sel & open_v & ~ras_ok_v))
            rsn = RSN_RAS;
         else if (op == OP_ACT && rrd_busy)
            rsn = RSN_RRD;
      end
   end

   assign accept = (rsn == RSN_NONE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         viol      <= 1'b0;
         viol_code <= '0;
      end else begin
         viol      <= !accept;
         viol_code <= rsn;
      end
   end

endmodule

// File: rtl/bank_rule_monitor_sva.sv
module bank_rule_monitor_sva
   import bank_mon_pkg::*;
#(
   parameter int  NUM_BANKS = 4,
   localparam int BANK_W    = $clog2(NUM_BANKS)
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   cke,
   input logic                   cs_n,
   input logic                   ras_n,
   input logic                   cas_n,
   input logic                   we_n,
   input logic [BANK_W-1:0]      bank,
   input logic                   a10,
   input logic [3*NUM_BANKS-1:0] bank_state,
   input logic                   all_idle,
   input logic                   viol,
   input logic [3:0]             viol_code
);

   assert_inhibit_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_n || !cke || {ras_n, cas_n, we_n} == 3'b111) |=> !viol);

   assert_flag_has_reason_R2: assert property (@(posedge clk) disable iff (!rst_n)
      viol |-> (viol_code != 4'd0));

   assert_refresh_needs_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cke && !cs_n && {ras_n, cas_n, we_n} == 3'b001 && !all_idle) |=> viol);

   for (genvar i = 0; i < NUM_BANKS; i++) begin : g_chk
      assert_open_via_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
         (bank_state[3*i +: 3] == BK_IDLE) |=>
            (bank_state[3*i +: 3] == BK_IDLE || bank_state[3*i +: 3] == BK_OPENING));

      assert_read_idle_flagged_R4: assert property (@(posedge clk) disable iff (!rst_n)
         (cke && !cs_n && {ras_n, cas_n, we_n} == 3'b101 && bank == BANK_W'(i) &&
          bank_state[3*i +: 3] == BK_IDLE) |=> viol);

      assert_autoclose_exit_R7: assert property (@(posedge clk) disable iff (!rst_n)
         (bank_state[3*i +: 3] == BK_AUTOCLOSE) |=>
            (bank_state[3*i +: 3] == BK_AUTOCLOSE || bank_state[3*i +: 3] == BK_IDLE));
   end

   // a10 is only relevant to the design, not to these checks
   logic unused_a10;
   assign unused_a10 = a10;

endmodule

bind bank_rule_monitor bank_rule_monitor_sva #(.NUM_BANKS(NUM_BANKS)) i_rule_sva (
   .clk        (clk),
   .rst_n      (rst_n),
   .cke        (cke),
   .cs_n       (cs_n),
   .ras_n      (ras_n),
   .cas_n      (cas_n),
   .we_n       (we_n),
   .bank       (bank),
   .a10        (a10),
   .bank_state (bank_state),
   .all_idle   (all_idle),
   .viol       (viol),
   .viol_code  (viol_code)
);

// File: tb/test_bank_rule_monitor.sv
module test_bank_rule_monitor;

   localparam logic [3:0] E_NOP  = 4'b0111;
   localparam logic [3:0] E_ACT  = 4'b0011;
   localparam logic [3:0] E_RD   = 4'b0101;
   localparam logic [3:0] E_WR   = 4'b0100;
   localparam logic [3:0] E_BST  = 4'b0110;
   localparam logic [3:0] E_PRE  = 4'b0010;
   localparam logic [3:0] E_REF  = 4'b0001;
   localparam logic [3:0] E_MODE = 4'b0000;
   localparam logic [3:0] E_INH  = 4'b1011;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cke = 1'b1;
   logic       cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
   logic [1:0] bank = '0;
   logic       a10 = 1'b0;
   logic [11:0] bank_state;
   logic       all_idle, viol;
   logic [3:0] viol_code;

   typedef struct {
      logic [3:0] code;
      string      tag;
   } exp_t;

   exp_t q[$];
   int   checks = 0;
   int   fails  = 0;
   bit   done   = 1'b0;

   always #2 clk = ~clk;

   bank_rule_monitor i_bank_rule_monitor (
      .clk        (clk),
      .rst_n      (rst_n),
      .cke        (cke),
      .cs_n       (cs_n),
      .ras_n      (ras_n),
      .cas_n      (cas_n),
      .we_n       (we_n),
      .bank       (bank),
      .a10        (a10),
      .bank_state (bank_state),
      .all_idle   (all_idle),
      .viol       (viol),
      .viol_code  (viol_code)
   );

   // driver: one command per cycle, expected reason pushed to the scoreboard
   task automatic issue(input logic [3:0] enc, input int b, input logic ap,
                        input logic ck, input logic [3:0] exp_c, input string tag);
      @(negedge clk);
      {cs_n, ras_n, cas_n, we_n} = enc;
      bank = 2'(b);
      a10  = ap;
      cke  = ck;
      q.push_back('{exp_c, tag});
      @(posedge clk);
      #1;
      cs_n = 1'b1;
      cke  = 1'b1;
      a10  = 1'b0;
   endtask

   task automatic nops(input int n);
      for (int k = 0; k < n; k++) issue(E_NOP, 0, 1'b0, 1'b1, 4'd0, "R1 no-op");
   endtask

   task automatic expect_state(input int b, input logic [2:0] s, input string tag);
      checks++;
      if (bank_state[3*b +: 3] !== s) begin
         fails++;
         $display("FAIL %s: bank %0d state actual=%0d expected=%0d", tag, b,
                  bank_state[3*b +: 3], s);
      end
   endtask

   task automatic expect_idle(input logic v, input string tag);
      checks++;
      if (all_idle !== v) begin
         fails++;
         $display("FAIL %s: all_idle actual=%0b expected=%0b", tag, all_idle, v);
      end
   endtask

   // monitor: compares each registered result against the queued expectation
   always @(posedge clk) begin
      exp_t e;
      #1;
      if (q.size() > 0) begin
         e = q.pop_front();
         checks++;
         if (viol !== (e.code != 4'd0) || viol_code !== e.code) begin
            fails++;
            $display("FAIL %s: viol=%0b code=%0d, expected viol=%0b code=%0d",
                     e.tag, viol, viol_code, (e.code != 4'd0), e.code);
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      for (int b = 0; b < 4; b++) expect_state(b, 3'd0, "R2 reset state");
      expect_idle(1'b1, "R2 reset all_idle");
      checks++;
      if (viol !== 1'b0) begin
         fails++;
         $display("FAIL R2 reset: viol actual=%0b expected=0", viol);
      end

      issue(E_ACT, 0, 1'b0, 1'b1, 4'd0, "R3 activate bank 0");
      expect_state(0, 3'd1, "R3 opening");
      issue(E_RD, 0, 1'b0, 1'b1, 4'd4, "R3 read inside tRCD");
      expect_state(0, 3'd2, "R3 open after tRCD");
      issue(E_RD, 0, 1'b0, 1'b1, 4'd0, "R2 legal read");
      expect_state(0, 3'd2, "R2 read keeps row open");
      issue(E_PRE, 0, 1'b0, 1'b1, 4'd7, "R11 precharge at tRAS-1");
      expect_state(0, 3'd2, "R2 rejected precharge dropped");
      issue(E_PRE, 0, 1'b0, 1'b1, 4'd0, "R11 precharge at tRAS");
      expect_state(0, 3'd3, "R5 closing");
      issue(E_ACT, 0, 1'b0, 1'b1, 4'd4, "R5 activate while closing");
      expect_state(0, 3'd0, "R5 idle after tRP");
      issue(E_RD, 0, 1'b0, 1'b1, 4'd5, "R4 read to idle bank");

      issue(E_ACT, 1, 1'b0, 1'b1, 4'd0, "R10 activate bank 1");
      issue(E_ACT, 2, 1'b0, 1'b1, 4'd8, "R10 activate inside tRRD");
      issue(E_ACT, 2, 1'b0, 1'b1, 4'd0, "R10 activate at tRRD");
      issue(E_ACT, 1, 1'b0, 1'b1, 4'd6, "R12 open row beats tRRD");
      issue(E_REF, 0, 1'b0, 1'b1, 4'd3, "R8 refresh with open banks");
      issue(E_MODE, 0, 1'b0, 1'b1, 4'd3, "R8 mode load with open banks");

      issue(E_WR, 1, 1'b1, 1'b1, 4'd0, "R7 write with auto-close");
      expect_state(1, 3'd4, "R7 auto-closing");
      issue(E_RD, 1, 1'b0, 1'b1, 4'd4, "R7 read during auto-close");
      issue(E_PRE, 3, 1'b1, 1'b1, 4'd4, "R6 precharge-all blocked by bank 1");
      nops(3);
      expect_state(1, 3'd0, "R7 idle after burst plus tRP");
      expect_state(2, 3'd2, "R6 bank 2 still open");
      issue(E_PRE, 1, 1'b1, 1'b1, 4'd0, "R6 precharge-all");
      expect_state(2, 3'd3, "R6 bank 2 closing");
      expect_state(0, 3'd0, "R6 idle bank untouched");
      expect_idle(1'b0, "R6 not all idle while closing");
      nops(1);
      expect_idle(1'b1, "R6 all idle after tRP");

      issue(E_REF, 0, 1'b0, 1'b1, 4'd0, "R8 refresh with all idle");
      issue(E_BST, 0, 1'b0, 1'b1, 4'd1, "R9 burst stop during tRC");
      nops(4);
      issue(E_ACT, 0, 1'b0, 1'b1, 4'd1, "R9 activate at tRC-1");
      expect_state(0, 3'd0, "R9 rejected activate dropped");
      issue(E_MODE, 0, 1'b0, 1'b1, 4'd0, "R9 mode load after tRC");
      issue(E_ACT, 0, 1'b0, 1'b1, 4'd2, "R9 activate inside tMRD");
      issue(E_ACT, 0, 1'b0, 1'b1, 4'd0, "R9 activate after tMRD");
      expect_state(0, 3'd1, "R3 opening again");

      issue(E_INH, 1, 1'b0, 1'b1, 4'd0, "R1 inhibited activate");
      expect_state(1, 3'd0, "R1 inhibit leaves bank idle");
      issue(E_RD, 3, 1'b0, 1'b0, 4'd0, "R1 read with cke low");
      issue(E_PRE, 3, 1'b0, 1'b1, 4'd0, "R5 precharge idle bank");
      expect_state(3, 3'd0, "R5 idle bank stays idle");

      issue(E_RD, 0, 1'b1, 1'b1, 4'd0, "R7 read with auto-close");
      expect_state(0, 3'd4, "R7 read auto-closing");
      nops(4);
      issue(E_ACT, 0, 1'b0, 1'b1, 4'd4, "R7 activate on last auto-close cycle");
      expect_state(0, 3'd0, "R7 idle after read auto-close");

      nops(1);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule